// File: doc/BRIEF.md
# MDIO Management Master

This block carries out one PHY register access over a two-wire management link for each command it receives from a register block. A command has three parts: a 2-bit opcode, a 26-bit word and a valid level. The word holds a 10-bit address in its upper bits and 16 bits of write data in its lower bits. The address splits into a 5-bit PHY number and a 5-bit register number. The valid level stays high for many cycles, and the block acts only on its rising edge.

The block builds the serial frame, divides the system clock down to MDC, and handles the turnaround. On a read it releases the data line and collects the 16 bits the PHY returns. At the end of every access it raises `rdValid` for one cycle. The requester treats the fall of `rdValid` as completion.

The MDC rate comes from a 32-bit configuration word. Only its low bits form the divisor. The word's reset value 0x00100000 has those bits at zero, which gives the fastest rate.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc`, `mdioOe`, `busy` and `rdValid` are low and `rdData` is zero.
- R2: Opcode 2'b10 starts a read and 2'b01 starts a write. Opcodes 2'b00 and 2'b11 start nothing: `busy`, `mdc` and `mdioOe` stay low.
- R3: Each rising edge of `cmdValid` starts exactly one transaction. Holding `cmdValid` high beyond the end of that transaction starts no second one.
- R4: A rising edge of `cmdValid` while `busy` is high is dropped. The frame in progress is not disturbed, even if `cmdWord` changes.
- R5: With N = `cfgWord[5:0]`, every MDC high phase and low phase lasts N+1 clock cycles. Bits [31:6] have no effect. MDC is low whenever the block is idle.
- R6: The frame is 64 bits, sent MSB first with one bit per MDC period. In order it holds: 32 ones, then 01, then the opcode, then the PHY number `cmdWord[25:21]`, then the register number `cmdWord[20:16]`, then two turnaround bits, then 16 data bits. Bits are stable at each MDC rising edge.
- R7: On a write, `mdioOe` is high for all 64 bits. The turnaround is 10 and the data is `cmdWord[15:0]`.
- R8: On a read, `mdioOe` is high for the first 46 bits and low for the turnaround and data bits. `mdioIn` is sampled at the 16 data-phase MDC rising edges, MSB first. The result appears on `rdData` at completion.
- R9: Each transaction raises `rdValid` high for exactly one cycle, for reads and writes alike. It rises in the cycle `busy` falls. `busy` lasts 128·(N+1) cycles.
- R10: A write completion leaves `rdData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdOpcode | input | 2 | 10 read, 01 write, other values ignored |
| cmdWord | input | 26 | {PHY[4:0], register[4:0], write data[15:0]} |
| cmdValid | input | 1 | Stretched command level; its rising edge starts an access |
| cfgWord | input | 32 | Configuration word; bits [5:0] set the MDC divisor |
| rdData | output | 16 | Data returned by the last read |
| rdValid | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Serial data driven toward the PHY |
| mdioOe | output | 1 | Output enable for the data pad |
| mdioIn | input | 1 | Serial data from the PHY |
| busy | output | 1 | High while a transaction is in progress |

## Verification
The bench builds the block with its default parameters: a 6-bit divisor field and a 32-bit preamble. It sweeps the divisor over 0, 1, 2 and 5, with the upper configuration bits set to ones. At these rates a full frame takes at most a few hundred cycles. This brings every opcode within reach, including both illegal ones, along with all-zero and all-one PHY and register numbers and data, a level held past the end of a frame, and a re-trigger in mid-frame. The bench models the PHY, which drives read data after each MDC fall. Expected frames, output-enable masks, phase lengths and busy durations are all computed arithmetically.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam int CMD_W = 26;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;     // capture a new command and build the frame
    logic shift;    // advance to the next bit after an MDC fall
    logic sample;   // capture mdioIn on an MDC rise in the data phase
    logic enterTa;  // next bit is the first turnaround bit
    logic finish;   // last MDC fall of the frame
  } mdioStb_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOpcode,
  input  logic [DIV_W-1:0] cfgDiv,
  output mdioStb_t         stb,
  output logic             mdc,
  output logic             busy,
  output logic             rdValid
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int CNT_W     = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] PRE_TA   = CNT_W'(PRE_LEN + 13);
  localparam logic [CNT_W-1:0] DATA_POS = CNT_W'(PRE_LEN + 16);

  logic             validD;
  logic             running;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLim;
  logic [CNT_W-1:0] bitCnt;
  logic             opOk;
  logic             start;
  logic             tick;

  assign opOk  = (cmdOpcode == OP_READ) || (cmdOpcode == OP_WRITE);
  assign start = cmdValid && !validD && !running && opOk;
  assign tick  = running && (divCnt == divLim);

  always_comb begin
    stb         = '0;
    stb.load    = start;
    stb.sample  = tick && !mdc && (bitCnt >= DATA_POS);
    stb.shift   = tick && mdc && (bitCnt != LAST_BIT);
    stb.enterTa = tick && mdc && (bitCnt == PRE_TA);
    stb.finish  = tick && mdc && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validD  <= 1'b0;
      running <= 1'b0;
      divCnt  <= '0;
      divLim  <= '0;
      bitCnt  <= '0;
      mdc     <= 1'b0;
      rdValid <= 1'b0;
    end else begin
      validD  <= cmdValid;
      rdValid <= stb.finish;
      if (start) begin
        running <= 1'b1;
        divCnt  <= '0;
        divLim  <= cfgDiv;
        bitCnt  <= '0;
        mdc     <= 1'b0;
      end else if (running) begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) mdc <= !mdc;
        if (stb.shift) bitCnt <= bitCnt + 1'b1;
        if (stb.finish) running <= 1'b0;
      end
    end
  end

  assign busy = running;

  a_r5_mdc_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);
  a_r9_pulse_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> rdValid);
  a_r2_bad_op_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !validD && !busy && cmdOpcode != OP_READ && cmdOpcode != OP_WRITE) |=> !busy);
  a_r4_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.finish) |=> (busy && $stable(divLim)));
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  mdioStb_t         stb,
  input  logic [1:0]       cmdOpcode,
  input  logic [CMD_W-1:0] cmdWord,
  input  logic             mdioIn,
  output logic             mdioOut,
  output logic             mdioOe,
  output logic [15:0]      rdData
);
  localparam int FRAME_LEN = PRE_LEN + 32;

  logic [FRAME_LEN-1:0] frameSr;
  logic [15:0]          capt;
  logic                 isRead;
  logic                 oeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSr <= '1;
      capt    <= '0;
      isRead  <= 1'b0;
      oeReg   <= 1'b0;
      rdData  <= '0;
    end else begin
      if (stb.load) begin
        frameSr <= {{PRE_LEN{1'b1}}, 2'b01, cmdOpcode, cmdWord[25:21],
                    cmdWord[20:16], 2'b10, cmdWord[15:0]};
        isRead  <= (cmdOpcode == OP_READ);
        oeReg   <= 1'b1;
      end
      if (stb.shift) begin
        frameSr <= {frameSr[FRAME_LEN-2:0], 1'b1};
        if (stb.enterTa && isRead) oeReg <= 1'b0;
      end
      if (stb.sample) capt <= {capt[14:0], mdioIn};
      if (stb.finish) begin
        frameSr <= '1;
        oeReg   <= 1'b0;
        if (isRead) rdData <= capt;
      end
    end
  end

  assign mdioOut = frameSr[FRAME_LEN-1];
  assign mdioOe  = oeReg;

  a_r8_read_line_released: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sample && isRead) |-> !mdioOe);
  a_r7_write_line_driven: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sample && !isRead) |-> mdioOe);
  a_r6_drive_after_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> mdioOe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cmdOpcode,
  input  logic [CMD_W-1:0] cmdWord,
  input  logic             cmdValid,
  input  logic [31:0]      cfgWord,
  output logic [15:0]      rdData,
  output logic             rdValid,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  input  logic             mdioIn,
  output logic             busy
);
  mdioStb_t stb;

  mdio_ctrl #(.DIV_W(DIV_W), .PRE_LEN(PRE_LEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOpcode(cmdOpcode),
    .cfgDiv   (cfgWord[DIV_W-1:0]),
    .stb      (stb),
    .mdc      (mdc),
    .busy     (busy),
    .rdValid  (rdValid)
  );

  mdio_datapath #(.PRE_LEN(PRE_LEN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cmdOpcode(cmdOpcode),
    .cmdWord  (cmdWord),
    .mdioIn   (mdioIn),
    .mdioOut  (mdioOut),
    .mdioOe   (mdioOe),
    .rdData   (rdData)
  );

  a_r5_cfg_known: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(cfgWord));
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  import mdio_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cmdOpcode = 2'b00;
  logic [25:0] cmdWord = '0;
  logic        cmdValid = 1'b0;
  logic [31:0] cfgWord = 32'h0010_0000;
  logic [15:0] rdData;
  logic        rdValid, mdc, mdioOut, mdioOe, busy;
  logic        mdioIn = 1'b0;

  int checks = 0;
  int errors = 0;
  logic [15:0] lastRead = 16'h0;

  always #2 clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rstN(rstN), .cmdOpcode(cmdOpcode), .cmdWord(cmdWord),
    .cmdValid(cmdValid), .cfgWord(cfgWord), .rdData(rdData), .rdValid(rdValid),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one transaction with a PHY model; pokeAt>0 re-raises cmdValid mid-frame
  task automatic runTxn(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd, input logic [15:0] phyRd,
                        input int n, input int hold, input int pokeAt);
    logic [63:0] capOut = '0;
    logic [63:0] capOe = '0;
    logic [63:0] expFrame, expOe;
    int rises = 0, falls = 0, busyCnt = 0, pulseCnt = 0, badPhase = 0, run = 0, cyc = 0;
    logic prevMdc = 1'b0;
    @(negedge clk);
    cfgWord   = 32'hFFFF_FFC0 | 32'(n);
    cmdOpcode = op;
    cmdWord   = {phy, rg, wd};
    cmdValid  = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (pokeAt > 0 && cyc == pokeAt) begin cmdValid = 1'b0; cmdWord = ~{phy, rg, wd}; end
      if (pokeAt > 0 && cyc == pokeAt + 2) cmdValid = 1'b1;
      if (cyc == hold) cmdValid = 1'b0;
      if (busy) busyCnt++;
      if (rdValid) pulseCnt++;
      if (mdc != prevMdc) begin
        if (run != n + 1) badPhase++;
        run = 1;
        if (mdc) begin
          if (rises < 64) begin capOut[63-rises] = mdioOut; capOe[63-rises] = mdioOe; end
          rises++;
        end else falls++;
      end else run++;
      prevMdc = mdc;
      if (!mdc && falls >= 48 && falls <= 63) mdioIn = phyRd[63-falls];
      if (cyc >= hold && pulseCnt > 0 && !busy && !rdValid) break;
      if (cyc > hold + 200 * (n + 1)) break;
    end
    cmdWord  = {phy, rg, wd};
    expFrame = {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, wd};
    expOe    = (op == OP_READ) ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    chk(rises == 64, "R6", "mdc rising edges", rises, 64);
    chk(((capOut ^ expFrame) & expOe) == 0, "R6", "frame bits", capOut & expOe, expFrame & expOe);
    if (op == OP_READ) chk(capOe == expOe, "R8", "read oe mask", capOe, expOe);
    else               chk(capOe == expOe, "R7", "write oe mask", capOe, expOe);
    chk(badPhase == 0, "R5", "mdc phase length errors", badPhase, 0);
    chk(busyCnt == 128 * (n + 1), "R9", "busy cycles", busyCnt, 128 * (n + 1));
    chk(pulseCnt == 1, "R3", "completion pulses", pulseCnt, 1);
    if (op == OP_READ) begin
      chk(rdData == phyRd, "R8", "read data", rdData, phyRd);
      lastRead = phyRd;
    end else chk(rdData == lastRead, "R10", "rdData after write", rdData, lastRead);
  endtask

  task automatic badOp(input logic [1:0] op);
    int act = 0;
    @(negedge clk);
    cmdOpcode = op;
    cmdWord   = 26'h2AA_AAAA;
    cmdValid  = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (i == 31) cmdValid = 1'b0;
      if (busy || mdc || mdioOe || rdValid) act++;
    end
    chk(act == 0, "R2", "activity on illegal opcode", act, 0);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nList[4] = '{0, 1, 2, 5};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!mdc && !mdioOe && !busy && !rdValid, "R1", "control outputs after reset",
        {mdc, mdioOe, busy, rdValid}, 0);
    chk(rdData == 0, "R1", "rdData after reset", rdData, 0);
    badOp(2'b00);
    badOp(2'b11);
    foreach (nList[i]) begin
      for (int k = 0; k < 3; k++) begin
        for (int o = 0; o < 2; o++) begin
          logic [1:0] op = o ? OP_READ : OP_WRITE;
          logic [4:0] phy = (k == 0) ? 5'h00 : (k == 1) ? 5'h1F : 5'h15;
          logic [4:0] rg  = (k == 0) ? 5'h1F : (k == 1) ? 5'h00 : 5'h0A;
          logic [15:0] wd = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h0000 : 16'hA5C3;
          logic [15:0] pr = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : (16'h3C5A ^ 16'(nList[i]));
          runTxn(op, phy, rg, wd, pr, nList[i], 31, 0);
        end
      end
    end
    // R3: level held well past the end of the frame
    runTxn(OP_READ, 5'h0C, 5'h13, 16'h1234, 16'hBEEF, 0, 300, 0);
    // R4: re-trigger with a new word while busy is dropped
    runTxn(OP_WRITE, 5'h07, 5'h19, 16'h5A0F, 16'h0, 1, 200, 60);
    runTxn(OP_READ, 5'h11, 5'h02, 16'h0, 16'h8001, 2, 300, 100);
    // R5: idle after traffic
    badOp(2'b11);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule